// File: doc/BRIEF.md
# Opcode Intercept and Substitution Unit

This unit sits on the read path between program memory and a byte-wide 8-bit CPU. When the CPU flags an opcode fetch with its sync strobe, the unit examines the byte coming from memory. If the byte is one of the extension opcodes that the CPU leaves unused, the unit hands the CPU a standard opcode in its place. It also raises side-band controls for the rest of that instruction. On every other bus cycle the byte goes through untouched.

The side-band controls are:
- a bank-pointer select (first data pointer, second data pointer or code pointer) for the external 24-bit address mux;
- a request to swap the next and current code pointers;
- a push enable with the name of the pointer to drive during the stack write;
- a pull enable with the name of the register that captures the pulled byte.

Prefix opcodes become a one-cycle no-op. The pointer they name is held pending and applied to the instruction that follows. Combined opcodes carry their own pointer and apply it to themselves.

Top module: `ossUnit`

## Requirements
- R1: While `syncIn` is low, `cpuData` equals `memData` in the same cycle.
- R2: On a sync cycle, prefix opcodes 83, C3 and 43 are given to the CPU as 03. During the prefix itself, `bankSel` reads 0. From the cycle after the next sync until the sync after that, `bankSel` reads 1, 2 or 3 respectively (1 = first data pointer, 2 = second data pointer, 3 = code pointer).
- R3: Combined loads F3→A1, E3→B1 and D3→AD set `bankSel`=2 from the cycle after their sync until the next sync.
- R4: Combined stores and bit operations B3→81, A3→91, 93→8D, 8B→0C and 9B→1C set `bankSel`=1 for their duration.
- R5: Far transfers 13→4C, 23→20, EB→60 and FB→40 hold `exchReq` high for their duration, with `bankSel`=0.
- R6: Pushes 6B, 7B, 4B and 5B are given as 08 and hold `pushEn` high, with `pushSel` = 0, 1, 2 or 3 respectively (0 = first data pointer, 1 = second, 2 = current code pointer, 3 = next code pointer).
- R7: Pulls 63, 73, 53, 1B and 2B are given as 7A and hold `pullEn` high, with `pullSel` = 0, 1, 2, 3 or 4 respectively (0 = first data pointer, 1 = second, 2 = next code pointer, 3 = instruction pointer low byte, 4 = instruction pointer high byte).
- R8: Opcode 0B is given as DC and raises no control.
- R9: Any other byte on a sync cycle passes unchanged. This includes 03, 42, DC, 5C and ordinary opcodes. All controls then read 0 for that instruction.
- R10: Controls change only at the clock edge that ends a sync cycle. On every other edge they hold.
- R11: Reset (`rstN` low) clears all controls and any pending prefix. A prefix followed by reset leaves the next instruction unselected.
- R12: When two prefixes come in a row, the later one applies. When a combined opcode follows a prefix, the combined opcode's own pointer wins over the pending one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| syncIn | input | 1 | Opcode fetch strobe from the CPU |
| memData | input | 8 | Byte read from memory |
| cpuData | output | 8 | Byte given to the CPU |
| bankSel | output | 2 | Pointer select for the current instruction |
| exchReq | output | 1 | Swap next and current code pointers |
| pushEn | output | 1 | Drive a pointer byte during the stack write |
| pushSel | output | 2 | Pointer to drive on push |
| pullEn | output | 1 | Capture the pulled byte |
| pullSel | output | 3 | Register capturing the pulled byte |

## Verification
A wrong substitution entry shows at `cpuData` in the same sync cycle, because the byte path is combinational. A wrong or stale control register shows one cycle later, at the first operand cycle of the instruction. A lost or misrouted pending prefix stays hidden through the prefix's own cycle. It only appears at the cycle after the next sync, as a wrong `bankSel` on the following instruction. For that reason each prefix case is checked across two instructions, and a reset is placed between a prefix and its consumer.

// File: rtl/ossPkg.sv
package ossPkg;
  localparam int OP_W    = 8;
  localparam int SEL_W   = 2;
  localparam int PUSH_W  = 2;
  localparam int PULL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_NONE = 2'd0, SEL_DP0 = 2'd1, SEL_DP1 = 2'd2, SEL_NCP = 2'd3
  } bankSel_t;

  typedef enum logic [PUSH_W-1:0] {
    PUSH_DP0 = 2'd0, PUSH_DP1 = 2'd1, PUSH_CCP = 2'd2, PUSH_NCP = 2'd3
  } pushSrc_t;

  typedef enum logic [PULL_W-1:0] {
    PULL_DP0 = 3'd0, PULL_DP1 = 3'd1, PULL_NCP = 3'd2,
    PULL_IPL = 3'd3, PULL_IPH = 3'd4
  } pullDst_t;

  // strobes from control to datapath
  typedef struct packed {
    logic fetch;
  } ctlStrobe_t;

  // decoded class of the fetched byte, datapath to control
  typedef struct packed {
    bankSel_t prefixSel;
    bankSel_t implSel;
    logic     exch;
    logic     push;
    pushSrc_t pushSrc;
    logic     pull;
    pullDst_t pullDst;
  } opInfo_t;
endpackage

// File: rtl/ossDatapath.sv
module ossDatapath
  import ossPkg::*;
(
  input  ctlStrobe_t       strb,
  input  logic [OP_W-1:0]  memData,
  output logic [OP_W-1:0]  cpuData,
  output opInfo_t          info
);
  localparam logic [OP_W-1:0] OP_NOP1 = 8'h03;
  localparam logic [OP_W-1:0] OP_PUSH = 8'h08;
  localparam logic [OP_W-1:0] OP_PULL = 8'h7A;

  logic [OP_W-1:0] subByte;

  always_comb begin
    subByte        = memData;
    info           = '0;
    info.prefixSel = SEL_NONE;
    info.implSel   = SEL_NONE;
    info.pushSrc   = PUSH_DP0;
    info.pullDst   = PULL_DP0;
    unique case (memData)
      8'h83: begin subByte = OP_NOP1; info.prefixSel = SEL_DP0; end
      8'hC3: begin subByte = OP_NOP1; info.prefixSel = SEL_DP1; end
      8'h43: begin subByte = OP_NOP1; info.prefixSel = SEL_NCP; end
      8'hF3: begin subByte = 8'hA1; info.implSel = SEL_DP1; end
      8'hE3: begin subByte = 8'hB1; info.implSel = SEL_DP1; end
      8'hD3: begin subByte = 8'hAD; info.implSel = SEL_DP1; end
      8'hB3: begin subByte = 8'h81; info.implSel = SEL_DP0; end
      8'hA3: begin subByte = 8'h91; info.implSel = SEL_DP0; end
      8'h93: begin subByte = 8'h8D; info.implSel = SEL_DP0; end
      8'h8B: begin subByte = 8'h0C; info.implSel = SEL_DP0; end
      8'h9B: begin subByte = 8'h1C; info.implSel = SEL_DP0; end
      8'h13: begin subByte = 8'h4C; info.exch = 1'b1; end
      8'h23: begin subByte = 8'h20; info.exch = 1'b1; end
      8'hEB: begin subByte = 8'h60; info.exch = 1'b1; end
      8'hFB: begin subByte = 8'h40; info.exch = 1'b1; end
      8'h6B: begin subByte = OP_PUSH; info.push = 1'b1; info.pushSrc = PUSH_DP0; end
      8'h7B: begin subByte = OP_PUSH; info.push = 1'b1; info.pushSrc = PUSH_DP1; end
      8'h4B: begin subByte = OP_PUSH; info.push = 1'b1; info.pushSrc = PUSH_CCP; end
      8'h5B: begin subByte = OP_PUSH; info.push = 1'b1; info.pushSrc = PUSH_NCP; end
      8'h63: begin subByte = OP_PULL; info.pull = 1'b1; info.pullDst = PULL_DP0; end
      8'h73: begin subByte = OP_PULL; info.pull = 1'b1; info.pullDst = PULL_DP1; end
      8'h53: begin subByte = OP_PULL; info.pull = 1'b1; info.pullDst = PULL_NCP; end
      8'h1B: begin subByte = OP_PULL; info.pull = 1'b1; info.pullDst = PULL_IPL; end
      8'h2B: begin subByte = OP_PULL; info.pull = 1'b1; info.pullDst = PULL_IPH; end
      8'h0B: subByte = 8'hDC;
      default: ;
    endcase
  end

  // rewrite only during opcode fetch
  assign cpuData = strb.fetch ? subByte : memData;
endmodule

// File: rtl/ossControl.sv
module ossControl
  import ossPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       syncIn,
  input  opInfo_t    info,
  output ctlStrobe_t strb,
  output bankSel_t   actSel,
  output logic       exchQ,
  output logic       pushQ,
  output pushSrc_t   pushSrcQ,
  output logic       pullQ,
  output pullDst_t   pullDstQ
);
  bankSel_t pendSel;
  logic     isPrefix;

  assign strb.fetch = syncIn;
  assign isPrefix   = (info.prefixSel != SEL_NONE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendSel  <= SEL_NONE;
      actSel   <= SEL_NONE;
      exchQ    <= 1'b0;
      pushQ    <= 1'b0;
      pushSrcQ <= PUSH_DP0;
      pullQ    <= 1'b0;
      pullDstQ <= PULL_DP0;
    end else if (strb.fetch) begin
      exchQ    <= info.exch;
      pushQ    <= info.push;
      pushSrcQ <= info.pushSrc;
      pullQ    <= info.pull;
      pullDstQ <= info.pullDst;
      if (isPrefix) begin
        pendSel <= info.prefixSel;
        actSel  <= SEL_NONE;
      end else begin
        pendSel <= SEL_NONE;
        actSel  <= (info.implSel != SEL_NONE) ? info.implSel : pendSel;
      end
    end
  end
endmodule

// File: rtl/ossUnit.sv
module ossUnit
  import ossPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncIn,
  input  logic [7:0]  memData,
  output logic [7:0]  cpuData,
  output logic [1:0]  bankSel,
  output logic        exchReq,
  output logic        pushEn,
  output logic [1:0]  pushSel,
  output logic        pullEn,
  output logic [2:0]  pullSel
);
  ctlStrobe_t strb;
  opInfo_t    info;
  bankSel_t   actSel;
  pushSrc_t   pushSrcQ;
  pullDst_t   pullDstQ;

  ossDatapath i_dp (
    .strb(strb), .memData(memData), .cpuData(cpuData), .info(info)
  );

  ossControl i_ctl (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .info(info), .strb(strb),
    .actSel(actSel), .exchQ(exchReq), .pushQ(pushEn), .pushSrcQ(pushSrcQ),
    .pullQ(pullEn), .pullDstQ(pullDstQ)
  );

  assign bankSel = actSel;
  assign pushSel = pushSrcQ;
  assign pullSel = pullDstQ;
endmodule

// File: rtl/ossUnitChecker.sv
module ossUnitChecker (
  input logic       clk,
  input logic       rstN,
  input logic       syncIn,
  input logic [7:0] memData,
  input logic [7:0] cpuData,
  input logic [1:0] bankSel,
  input logic       exchReq,
  input logic       pushEn,
  input logic [1:0] pushSel,
  input logic       pullEn,
  input logic [2:0] pullSel
);
  logic isPfx;
  assign isPfx = (memData == 8'h83) || (memData == 8'hC3) || (memData == 8'h43);

  a_r1_pass_outside_fetch: assert property (@(posedge clk) disable iff (!rstN)
    !syncIn |-> cpuData == memData);

  a_r2_prefix_to_nop: assert property (@(posedge clk) disable iff (!rstN)
    syncIn && isPfx |-> cpuData == 8'h03);

  a_r2_prefix_no_own_sel: assert property (@(posedge clk) disable iff (!rstN)
    syncIn && isPfx |=> bankSel == 2'd0 && !exchReq && !pushEn && !pullEn);

  a_r5_far_jump_exch: assert property (@(posedge clk) disable iff (!rstN)
    syncIn && memData == 8'h13 |=> exchReq && bankSel == 2'd0);

  a_r9_nop_kept: assert property (@(posedge clk) disable iff (!rstN)
    syncIn && memData == 8'h03 |-> cpuData == 8'h03);

  a_r10_hold_between_fetch: assert property (@(posedge clk) disable iff (!rstN)
    !syncIn |=> $stable({bankSel, exchReq, pushEn, pushSel, pullEn, pullSel}));

  a_r5_side_effects_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({exchReq, pushEn, pullEn}));
endmodule

bind ossUnit ossUnitChecker i_chk (
  .clk(clk), .rstN(rstN), .syncIn(syncIn), .memData(memData), .cpuData(cpuData),
  .bankSel(bankSel), .exchReq(exchReq), .pushEn(pushEn), .pushSel(pushSel),
  .pullEn(pullEn), .pullSel(pullSel)
);

// File: tb/test_ossUnit.sv
module test_ossUnit;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       syncIn = 1'b0;
  logic [7:0] memData = 8'h00;
  logic [7:0] cpuData;
  logic [1:0] bankSel;
  logic       exchReq, pushEn, pullEn;
  logic [1:0] pushSel;
  logic [2:0] pullSel;
  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ossUnit i_ossUnit (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .memData(memData), .cpuData(cpuData),
    .bankSel(bankSel), .exchReq(exchReq), .pushEn(pushEn), .pushSel(pushSel),
    .pullEn(pullEn), .pullSel(pullSel)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one sync cycle; on return the post-edge controls are visible
  task automatic syncCycle(input logic [7:0] op, input logic [7:0] expSub, input string tag);
    syncIn = 1'b1; memData = op;
    #1 check(tag, {8'h0, cpuData}, {8'h0, expSub});
    @(negedge clk);
  endtask

  task automatic dataCycle(input logic [7:0] b);
    syncIn = 1'b0; memData = b;
    #1 check("R1 passthrough", {8'h0, cpuData}, {8'h0, b});
    @(negedge clk);
  endtask

  task automatic checkCtl(input logic [1:0] eSel, input logic eEx, input logic ePush,
                          input logic [1:0] ePs, input logic ePull, input logic [2:0] ePl,
                          input string tag);
    check(tag, {6'h0, bankSel, exchReq, pushEn, pushSel, pullEn, pullSel},
               {6'h0, eSel, eEx, ePush, ePs, ePull, ePl});
  endtask

  // instruction with one operand cycle: controls set and held (R10)
  task automatic farOp(input logic [7:0] op, input logic [7:0] sub, input logic [1:0] sel,
                       input logic ex, input logic pu, input logic [1:0] ps,
                       input logic pl, input logic [2:0] pd, input string tag);
    syncCycle(op, sub, tag);
    checkCtl(sel, ex, pu, ps, pl, pd, tag);
    dataCycle(8'h5A);
    checkCtl(sel, ex, pu, ps, pl, pd, "R10 hold");
  endtask

  task automatic testReset;
    checkCtl(2'd0, 0, 0, 2'd0, 0, 3'd0, "R11 reset state");
    dataCycle(8'hC3);
  endtask

  task automatic testPrefix;
    syncCycle(8'h83, 8'h03, "R2 prefix DP0");
    checkCtl(2'd0, 0, 0, 2'd0, 0, 3'd0, "R2 prefix own cycle");
    farOp(8'hA9, 8'hA9, 2'd1, 0, 0, 2'd0, 0, 3'd0, "R2 DP0 applied");
    syncCycle(8'hC3, 8'h03, "R2 prefix DP1");
    farOp(8'hBD, 8'hBD, 2'd2, 0, 0, 2'd0, 0, 3'd0, "R2 DP1 applied");
    syncCycle(8'h43, 8'h03, "R2 prefix NCP");
    farOp(8'h8D, 8'h8D, 2'd3, 0, 0, 2'd0, 0, 3'd0, "R2 NCP applied");
    farOp(8'hEA, 8'hEA, 2'd0, 0, 0, 2'd0, 0, 3'd0, "R2 select cleared");
  endtask

  task automatic testCombined;
    farOp(8'hF3, 8'hA1, 2'd2, 0, 0, 2'd0, 0, 3'd0, "R3 F3");
    farOp(8'hE3, 8'hB1, 2'd2, 0, 0, 2'd0, 0, 3'd0, "R3 E3");
    farOp(8'hD3, 8'hAD, 2'd2, 0, 0, 2'd0, 0, 3'd0, "R3 D3");
    farOp(8'hB3, 8'h81, 2'd1, 0, 0, 2'd0, 0, 3'd0, "R4 B3");
    farOp(8'hA3, 8'h91, 2'd1, 0, 0, 2'd0, 0, 3'd0, "R4 A3");
    farOp(8'h93, 8'h8D, 2'd1, 0, 0, 2'd0, 0, 3'd0, "R4 93");
    farOp(8'h8B, 8'h0C, 2'd1, 0, 0, 2'd0, 0, 3'd0, "R4 8B");
    farOp(8'h9B, 8'h1C, 2'd1, 0, 0, 2'd0, 0, 3'd0, "R4 9B");
  endtask

  task automatic testTransfer;
    farOp(8'h13, 8'h4C, 2'd0, 1, 0, 2'd0, 0, 3'd0, "R5 13");
    farOp(8'h23, 8'h20, 2'd0, 1, 0, 2'd0, 0, 3'd0, "R5 23");
    farOp(8'hEB, 8'h60, 2'd0, 1, 0, 2'd0, 0, 3'd0, "R5 EB");
    farOp(8'hFB, 8'h40, 2'd0, 1, 0, 2'd0, 0, 3'd0, "R5 FB");
  endtask

  task automatic testPushPull;
    farOp(8'h6B, 8'h08, 2'd0, 0, 1, 2'd0, 0, 3'd0, "R6 6B");
    farOp(8'h7B, 8'h08, 2'd0, 0, 1, 2'd1, 0, 3'd0, "R6 7B");
    farOp(8'h4B, 8'h08, 2'd0, 0, 1, 2'd2, 0, 3'd0, "R6 4B");
    farOp(8'h5B, 8'h08, 2'd0, 0, 1, 2'd3, 0, 3'd0, "R6 5B");
    farOp(8'h63, 8'h7A, 2'd0, 0, 0, 2'd0, 1, 3'd0, "R7 63");
    farOp(8'h73, 8'h7A, 2'd0, 0, 0, 2'd0, 1, 3'd1, "R7 73");
    farOp(8'h53, 8'h7A, 2'd0, 0, 0, 2'd0, 1, 3'd2, "R7 53");
    farOp(8'h1B, 8'h7A, 2'd0, 0, 0, 2'd0, 1, 3'd3, "R7 1B");
    farOp(8'h2B, 8'h7A, 2'd0, 0, 0, 2'd0, 1, 3'd4, "R7 2B");
  endtask

  task automatic testPassThrough;
    farOp(8'h0B, 8'hDC, 2'd0, 0, 0, 2'd0, 0, 3'd0, "R8 0B");
    syncCycle(8'h03, 8'h03, "R9 03 kept");
    checkCtl(2'd0, 0, 0, 2'd0, 0, 3'd0, "R9 03 no ctl");
    farOp(8'h42, 8'h42, 2'd0, 0, 0, 2'd0, 0, 3'd0, "R9 42");
    farOp(8'hDC, 8'hDC, 2'd0, 0, 0, 2'd0, 0, 3'd0, "R9 DC");
    farOp(8'h5C, 8'h5C, 2'd0, 0, 0, 2'd0, 0, 3'd0, "R9 5C");
    farOp(8'h33, 8'h33, 2'd0, 0, 0, 2'd0, 0, 3'd0, "R9 33");
    dataCycle(8'h83);
    checkCtl(2'd0, 0, 0, 2'd0, 0, 3'd0, "R1 prefix byte off-fetch ignored");
    farOp(8'hA9, 8'hA9, 2'd0, 0, 0, 2'd0, 0, 3'd0, "R1 no pending from data");
  endtask

  task automatic testOverride;
    syncCycle(8'h83, 8'h03, "R12 first prefix");
    syncCycle(8'h43, 8'h03, "R12 second prefix");
    farOp(8'hAD, 8'hAD, 2'd3, 0, 0, 2'd0, 0, 3'd0, "R12 later prefix wins");
    syncCycle(8'h83, 8'h03, "R12 prefix before combined");
    farOp(8'hF3, 8'hA1, 2'd2, 0, 0, 2'd0, 0, 3'd0, "R12 combined wins");
  endtask

  task automatic testResetMid;
    syncCycle(8'hC3, 8'h03, "R11 prefix before reset");
    syncIn = 1'b0; rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    checkCtl(2'd0, 0, 0, 2'd0, 0, 3'd0, "R11 cleared by reset");
    farOp(8'hA9, 8'hA9, 2'd0, 0, 0, 2'd0, 0, 3'd0, "R11 pending dropped");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPrefix();
    testCombined();
    testTransfer();
    testPushPull();
    testPassThrough();
    testOverride();
    testResetMid();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule